// File: doc/BRIEF.md
# UART Transmitter With Graceful Stop

This block is the transmit half of an asynchronous serial port. Software pushes characters into a four-entry queue. Each character carries two flags. One marks the last character of a buffer. The other selects when the end of that buffer is reported. A framing engine pops the characters one at a time and sends each one on the line. A frame is a low start bit, eight data bits sent least significant bit first, and a high stop bit. Each bit lasts sixteen baud ticks.

A graceful-stop command halts transmission at a buffer boundary. Any buffer already begun is sent to its end, and only then does the block halt. From that point the line stays high and nothing more is taken from the queue until a restart command arrives.

Two events are kept in a sticky status register:
- bit 0 means a buffer was sent;
- bit 1 means a graceful stop completed.

Software clears a status bit by writing a one to it.

The controller has two states. `C_RUN` moves to `C_HALT` when a stop is pending, no buffer is open and the framer is idle. `C_HALT` moves back to `C_RUN` on a restart command.

The framer has four states, taken in a fixed order:
- `F_IDLE` moves to `F_START` when a character is loaded;
- `F_START` moves to `F_DATA` after sixteen ticks;
- `F_DATA` moves to `F_STOP` after eight bits of sixteen ticks each;
- `F_STOP` moves to `F_IDLE` after sixteen ticks.

Top module: `uart_tx_gstop`

## Requirements
- R1: The idle line is 1. A frame is one 0 start bit, then 8 data bits LSB first, then one 1 stop bit. Each bit lasts exactly 16 cycles in which `baud_tick` is high.
- R2: Characters leave in the order they were accepted. `wr_ready` drops while 4 characters are queued, and a write made while `wr_ready` is low is discarded.
- R3: For a character written with `wr_last`=1 and `wr_line_rpt`=0, status bit 0 is set on the clock edge that accepts the write, before that character reaches the line.
- R4: For a last character written with `wr_line_rpt`=1, status bit 0 is set on the same clock edge on which the line enters that character's stop bit, and not before.
- R5: A `gs_cmd` pulse given while no buffer is open sets status bit 1 within two clock edges.
- R6: A `gs_cmd` pulse given during a buffer lets every remaining character of that buffer be sent. Status bit 1 is set only after the stop bit of the buffer's last character has ended.
- R7: After a graceful stop completes, no character is started and the line stays 1 until `restart_cmd` is pulsed. After the restart, the queued characters are sent.
- R8: A status bit stays set until a write with a 1 in that bit of `evt_clr`. Clearing one bit leaves the other unchanged.
- R9: After reset the line is 1, the status is 0 and `wr_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Oversampling tick, one per 1/16 bit |
| wr_valid | input | 1 | Queue write strobe |
| wr_data | input | 8 | Character to send |
| wr_last | input | 1 | Character closes its buffer |
| wr_line_rpt | input | 1 | Report buffer end at the line (1) or at the write (0) |
| wr_ready | output | 1 | Queue has room |
| gs_cmd | input | 1 | Graceful-stop command pulse |
| restart_cmd | input | 1 | Restart command pulse |
| evt_clr | input | 2 | Write-ones-to-clear for the status bits |
| tx_line | output | 1 | Serial output |
| evt_status | output | 2 | Sticky events: bit 0 buffer sent, bit 1 stop complete |

## Verification
A corrupted framer bit counter or tick counter shows on the line within one frame. A bit of the wrong length, or a byte decoded out of order, is caught at the next sample taken mid-bit.

A controller whose open-buffer flag is wrong shows in one of two ways:
- the stop-complete bit rises before the last stop bit has ended;
- characters of the next buffer leak out while the block should be halted.

Either fault appears within one frame time of the stop command. A wrong reporting mode moves status bit 0 by about a whole frame. It is therefore caught at the exact edge where the stop bit begins, or at the write that accepts the character.

// File: rtl/uart_tx_gstop_pkg.sv
package uart_tx_gstop_pkg;

    localparam int DATA_W = 8;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              last;
        logic              rpt;
    } txq_entry_t;

    typedef enum logic [1:0] {
        F_IDLE,
        F_START,
        F_DATA,
        F_STOP
    } frm_state_t;

    typedef enum logic {
        C_RUN,
        C_HALT
    } ctl_state_t;

endpackage

// File: rtl/txg_fifo.sv
module txg_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign full    = (cnt_q == CNT_FULL);
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // R2
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);

    // R2
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);

endmodule

// File: rtl/txg_framer.sv
module txg_framer
    import uart_tx_gstop_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          load,
    input  logic [DW-1:0] ld_data,
    input  logic          ld_last,
    input  logic          ld_rpt,
    output logic          idle,
    output logic          tx_line,
    output logic          stop_begin_rpt,
    output logic          done_last
);
    localparam int TW = $clog2(OVS);
    localparam int BW = $clog2(DW);
    localparam logic [TW-1:0] TICK_LAST = TW'(OVS - 1);
    localparam logic [BW-1:0] BIT_LAST  = BW'(DW - 1);

    frm_state_t    st_q, st_nx;
    logic [TW-1:0] tick_q;
    logic [BW-1:0] bit_q;
    logic [DW-1:0] sh_q;
    logic          last_q, rpt_q;
    logic          bit_end;

    assign bit_end = baud_tick && (tick_q == TICK_LAST);
    assign idle    = (st_q == F_IDLE);

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            F_IDLE:  if (load) st_nx = F_START;
            F_START: if (bit_end) st_nx = F_DATA;
            F_DATA:  if (bit_end && bit_q == BIT_LAST) st_nx = F_STOP;
            F_STOP:  if (bit_end) st_nx = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= F_IDLE;
            tick_q <= '0;
            bit_q  <= '0;
            sh_q   <= '0;
            last_q <= 1'b0;
            rpt_q  <= 1'b0;
        end else begin
            st_q <= st_nx;
            if (st_q == F_IDLE) begin
                tick_q <= '0;
                bit_q  <= '0;
                if (load) begin
                    sh_q   <= ld_data;
                    last_q <= ld_last;
                    rpt_q  <= ld_rpt;
                end
            end else if (baud_tick) begin
                tick_q <= tick_q + 1'b1;
                if (bit_end && st_q == F_DATA) begin
                    sh_q  <= sh_q >> 1;
                    bit_q <= bit_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        tx_line        = 1'b1;
        stop_begin_rpt = 1'b0;
        done_last      = 1'b0;
        unique case (st_q)
            F_IDLE:  tx_line = 1'b1;
            F_START: tx_line = 1'b0;
            F_DATA: begin
                tx_line        = sh_q[0];
                stop_begin_rpt = (st_nx == F_STOP) && last_q && rpt_q;
            end
            F_STOP: begin
                tx_line   = 1'b1;
                done_last = bit_end && last_q;
            end
        endcase
    end

    // R1
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && idle) |=> !tx_line);

    // R4
    stop_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_begin_rpt |=> tx_line);

endmodule

// File: rtl/txg_events.sv
module txg_events #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] status
);
    logic [N-1:0] st_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (st_q & ~clr) | set;
    end

    assign status = st_q;

    for (genvar i = 0; i < N; i++) begin : g_hold
        // R8
        sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q[i] && !clr[i]) |=> st_q[i]);
    end

endmodule

// File: rtl/uart_tx_gstop.sv
module uart_tx_gstop
    import uart_tx_gstop_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int OVS        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_last,
    input  logic              wr_line_rpt,
    output logic              wr_ready,
    input  logic              gs_cmd,
    input  logic              restart_cmd,
    input  logic [1:0]        evt_clr,
    output logic              tx_line,
    output logic [1:0]        evt_status
);
    localparam int EW = $bits(txq_entry_t);

    txq_entry_t q_head;
    logic       q_empty, q_full, pop;
    logic       f_idle, stop_begin_rpt, done_last;
    logic       gs_done, tx_evt;
    logic       gs_pend_q, in_buf_q;
    ctl_state_t ctl_q, ctl_nx;

    assign wr_ready = !q_full;

    txg_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_valid),
        .push_data ({wr_data, wr_last, wr_line_rpt}),
        .pop       (pop),
        .head      (q_head),
        .empty     (q_empty),
        .full      (q_full)
    );

    txg_framer #(.DW(DATA_W), .OVS(OVS)) i_framer (
        .clk            (clk),
        .rst_n          (rst_n),
        .baud_tick      (baud_tick),
        .load           (pop),
        .ld_data        (q_head.data),
        .ld_last        (q_head.last),
        .ld_rpt         (q_head.rpt),
        .idle           (f_idle),
        .tx_line        (tx_line),
        .stop_begin_rpt (stop_begin_rpt),
        .done_last      (done_last)
    );

    // Controller: state register and bookkeeping of the open buffer.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q     <= C_RUN;
            gs_pend_q <= 1'b0;
            in_buf_q  <= 1'b0;
        end else begin
            ctl_q     <= ctl_nx;
            gs_pend_q <= gs_done ? 1'b0 : (gs_pend_q | (gs_cmd && ctl_q == C_RUN));
            if (pop)            in_buf_q <= 1'b1;
            else if (done_last) in_buf_q <= 1'b0;
        end
    end

    // Controller: next state and outputs.
    always_comb begin
        ctl_nx  = ctl_q;
        pop     = 1'b0;
        gs_done = 1'b0;
        unique case (ctl_q)
            C_RUN: begin
                if (gs_pend_q && !in_buf_q && f_idle) begin
                    gs_done = 1'b1;
                    ctl_nx  = C_HALT;
                end else if (f_idle && !q_empty) begin
                    pop = 1'b1;
                end
            end
            C_HALT: if (restart_cmd) ctl_nx = C_RUN;
        endcase
    end

    assign tx_evt = (wr_valid && !q_full && wr_last && !wr_line_rpt) || stop_begin_rpt;

    txg_events #(.N(2)) i_events (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    ({gs_done, tx_evt}),
        .clr    (evt_clr),
        .status (evt_status)
    );

    // R7
    halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q == C_HALT) |-> tx_line);

    // R6
    gs_line_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gs_done |-> (tx_line && !$past(done_last && !f_idle) || tx_line));

    // R6
    gs_closed_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gs_done |=> (ctl_q == C_HALT));

endmodule

// File: tb/test_uart_tx_gstop.sv
module test_uart_tx_gstop;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_last = 1'b0;
    logic       wr_line_rpt = 1'b0;
    logic       wr_ready;
    logic       gs_cmd = 1'b0;
    logic       restart_cmd = 1'b0;
    logic [1:0] evt_clr = '0;
    logic       tx_line;
    logic [1:0] evt_status;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    uart_tx_gstop i_uart_tx_gstop (
        .clk         (clk),
        .rst_n       (rst_n),
        .baud_tick   (baud_tick),
        .wr_valid    (wr_valid),
        .wr_data     (wr_data),
        .wr_last     (wr_last),
        .wr_line_rpt (wr_line_rpt),
        .wr_ready    (wr_ready),
        .gs_cmd      (gs_cmd),
        .restart_cmd (restart_cmd),
        .evt_clr     (evt_clr),
        .tx_line     (tx_line),
        .evt_status  (evt_status)
    );

    // Baud tick generator: one tick every tick_div cycles.
    int tick_div = 1;
    int tcnt = 0;
    assign baud_tick = (tcnt == 0);
    always_ff @(posedge clk) tcnt <= (tcnt + 1 >= tick_div) ? 0 : tcnt + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Line monitor: decodes frames at mid-bit (one tick per cycle).
    bit         mon_en = 1;
    bit         mon_busy = 0;
    int         mon_t = 0;
    logic [7:0] mon_sh;
    logic [7:0] rx_mem [64];
    int         rx_cnt = 0;

    always @(negedge clk) begin
        if (mon_en && rst_n) begin
            if (!mon_busy) begin
                if (tx_line == 1'b0) begin
                    mon_busy = 1;
                    mon_t = 0;
                end
            end else begin
                mon_t++;
                if (mon_t == 8) chk(tx_line == 1'b0, "R1 start bit", tx_line, 0);
                for (int k = 1; k <= 8; k++)
                    if (mon_t == 16 * k + 8) mon_sh[k-1] = tx_line;
                if (mon_t == 152) begin
                    chk(tx_line == 1'b1, "R1 stop bit", tx_line, 1);
                    rx_mem[rx_cnt % 64] = mon_sh;
                    rx_cnt++;
                end
                if (mon_t == 156) mon_busy = 0;
            end
        end
    end

    task automatic wr(input logic [7:0] d, input bit last, input bit rpt);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1; wr_data = d; wr_last = last; wr_line_rpt = rpt;
        @(negedge clk);
        wr_valid = 1'b0; wr_last = 1'b0; wr_line_rpt = 1'b0;
    endtask

    task automatic pulse_clr(input logic [1:0] m);
        @(negedge clk); evt_clr = m;
        @(negedge clk); evt_clr = '0;
    endtask

    task automatic wait_rx(input int n);
        int guard = 0;
        while (rx_cnt < n && guard < 5000) begin @(negedge clk); guard++; end
    endtask

    // Stimulus table: {data, last, line_report}
    localparam logic [9:0] VEC [8] = '{
        {8'hA5, 1'b0, 1'b0}, {8'h3C, 1'b1, 1'b0},
        {8'h00, 1'b0, 1'b1}, {8'hFF, 1'b0, 1'b1},
        {8'h81, 1'b1, 1'b1}, {8'h7E, 1'b1, 1'b0},
        {8'h01, 1'b0, 1'b0}, {8'h80, 1'b1, 1'b1}
    };

    initial begin
        #2_000_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int base;
        int lowc;
        bit prev_st;
        bit stayed_high;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(tx_line == 1'b1, "R9 line", tx_line, 1);
        chk(evt_status == 2'b00, "R9 status", evt_status, 0);
        chk(wr_ready == 1'b1, "R9 ready", wr_ready, 1);
        rst_n = 1'b1;

        // R1 R2 table walk
        foreach (VEC[i]) wr(VEC[i][9:2], VEC[i][1], VEC[i][0]);
        wait_rx(8);
        foreach (VEC[i]) chk(rx_mem[i] == VEC[i][9:2], "R2 order", rx_mem[i], VEC[i][9:2]);
        repeat (20) @(negedge clk);
        chk(evt_status[0] == 1'b1, "R4 event after table", evt_status[0], 1);

        // R3 write-time report
        pulse_clr(2'b11);
        base = rx_cnt;
        wr(8'h12, 1'b0, 1'b0);
        chk(evt_status[0] == 1'b0, "R3 no event on non-last", evt_status[0], 0);
        wr(8'h34, 1'b1, 1'b0);
        chk(evt_status[0] == 1'b1, "R3 event at write", evt_status[0], 1);
        chk(rx_cnt == base, "R3 before line", rx_cnt, base);
        wait_rx(base + 2);
        chk(rx_mem[base + 1] == 8'h34, "R2 byte", rx_mem[base + 1], 8'h34);
        repeat (20) @(negedge clk);

        // R4 line-time report with an all-zero byte
        pulse_clr(2'b11);
        wr(8'h00, 1'b1, 1'b1);
        while (tx_line) @(negedge clk);
        lowc = 0; prev_st = evt_status[0];
        while (!tx_line && lowc < 400) begin
            prev_st = evt_status[0];
            lowc++;
            @(negedge clk);
        end
        chk(prev_st == 1'b0, "R4 not early", prev_st, 0);
        chk(evt_status[0] == 1'b1, "R4 at stop start", evt_status[0], 1);
        chk(lowc == 144, "R1 nine low bits", lowc, 144);
        repeat (20) @(negedge clk);

        // R5 graceful stop while idle
        pulse_clr(2'b11);
        @(negedge clk); gs_cmd = 1'b1;
        @(negedge clk); gs_cmd = 1'b0;
        @(negedge clk);
        chk(evt_status[1] == 1'b1, "R5 immediate", evt_status[1], 1);

        // R7 halted: queue fills, nothing leaves; R2 overflow dropped
        base = rx_cnt;
        for (int i = 0; i < 4; i++) wr(8'h40 + 8'(i), i == 3, 1'b0);
        @(negedge clk);
        chk(wr_ready == 1'b0, "R2 full", wr_ready, 0);
        wr_valid = 1'b1; wr_data = 8'hEE; wr_last = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0; wr_last = 1'b0;
        stayed_high = 1;
        repeat (300) begin @(negedge clk); if (!tx_line) stayed_high = 0; end
        chk(stayed_high, "R7 line held", stayed_high, 1);
        chk(rx_cnt == base, "R7 nothing sent", rx_cnt, base);
        @(negedge clk); restart_cmd = 1'b1;
        @(negedge clk); restart_cmd = 1'b0;
        wait_rx(base + 4);
        repeat (400) @(negedge clk);
        chk(rx_cnt == base + 4, "R2 dropped write", rx_cnt, base + 4);
        for (int i = 0; i < 4; i++)
            chk(rx_mem[base + i] == 8'h40 + 8'(i), "R7 resume", rx_mem[base + i], 8'h40 + i);

        // R6 graceful stop during a buffer
        pulse_clr(2'b11);
        base = rx_cnt;
        wr(8'hC1, 1'b0, 1'b0);
        wr(8'hC2, 1'b0, 1'b0);
        wr(8'hC3, 1'b1, 1'b0);
        wr(8'hD4, 1'b1, 1'b0);
        while (tx_line) @(negedge clk);
        gs_cmd = 1'b1;
        @(negedge clk); gs_cmd = 1'b0;
        wait_rx(base + 3);
        chk(evt_status[1] == 1'b0, "R6 not before stop end", evt_status[1], 0);
        repeat (20) @(negedge clk);
        chk(evt_status[1] == 1'b1, "R6 complete", evt_status[1], 1);
        chk(rx_mem[base + 2] == 8'hC3, "R6 whole buffer", rx_mem[base + 2], 8'hC3);
        repeat (400) @(negedge clk);
        chk(rx_cnt == base + 3, "R7 next buffer held", rx_cnt, base + 3);
        @(negedge clk); restart_cmd = 1'b1;
        @(negedge clk); restart_cmd = 1'b0;
        wait_rx(base + 4);
        chk(rx_mem[base + 3] == 8'hD4, "R7 after restart", rx_mem[base + 3], 8'hD4);
        repeat (20) @(negedge clk);

        // R8 write-ones-to-clear
        chk(evt_status == 2'b11, "R8 both set", evt_status, 3);
        pulse_clr(2'b00);
        chk(evt_status == 2'b11, "R8 zero write", evt_status, 3);
        pulse_clr(2'b10);
        chk(evt_status == 2'b01, "R8 clear bit1", evt_status, 1);
        pulse_clr(2'b01);
        chk(evt_status == 2'b00, "R8 clear bit0", evt_status, 0);

        // R1 tick-based bit length with a divided tick
        mon_en = 0;
        tick_div = 3;
        wr(8'h01, 1'b1, 1'b0);
        while (tx_line) @(negedge clk);
        lowc = 0;
        while (!tx_line && lowc < 200) begin lowc++; @(negedge clk); end
        chk(lowc >= 46 && lowc <= 48, "R1 sixteen ticks", lowc, 47);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule